// File: doc/BRIEF.md
# Sequenced ADC Conversion Controller

This block is the device-side control logic in front of an eight-input successive-approximation converter. A host reaches it through a small register port with 16-bit data and 4-bit addresses. One control word holds the enable, a start bit, a sync-mode bit, two reference options and a 3-bit input selector. A data word returns the 10-bit result and a flag that marks it as valid. The analog converter is modelled by one sampled 10-bit digital value per input.

Host software first writes the control word with the chosen input and then writes it again with the start bit added. That second write launches a timed sequence. A select phase of `SEL_CYC` serial-clock cycles lets the input settle. An optional gate then waits for an external sync strobe. A convert phase of `CONV_CYC` cycles follows. When the convert phase ends, the result is latched, the valid flag is set and a one-cycle completion event is raised on bit 11 of an interrupt source vector, which feeds an interrupt controller. Clearing the enable bit stops the sequence at any time.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, address 0xA and address 0xB both read 0x0000 and the interrupt vector is all zero.
- R2: Address 0xA reads back the bits last written to it at positions 15 (enable), 7 (start), 5 (external reference), 4:2 (input select), 1 (reference bypass) and 0 (sync mode). All other bit positions read 0. A write to any other address leaves the control word unchanged, and any address other than 0xA and 0xB reads 0.
- R3: Address 0xB reads the valid flag in bit 15 and the 10-bit result in bits 14:5. Bits 4:0 read 0.
- R4: A conversion is launched by a write to 0xA with bits 15 and 7 both set, when the stored bit 7 was 0. That write clears the valid flag. A launch during a conversion restarts the sequence from the select phase.
- R5: In the default configuration, with sync mode off, the result becomes valid and the completion event is raised 153 cycles after the launch edge (51 select cycles plus 102 convert cycles).
- R6: Input select code n (0 to 7) in bits 4:2 picks input n. The result equals that input's value as sampled when the convert phase begins.
- R7: With bit 0 set, the convert phase waits until the sync input is seen high at a clock edge after the launch edge. If that edge falls in the select phase, there is no extra delay. Otherwise the convert phase begins on that edge and completes 102 cycles later. With bit 0 clear, the sync input has no effect.
- R8: Completion raises bit 11 of the interrupt vector for exactly one cycle. All other bits of the vector stay 0.
- R9: While the stored start bit is 1, a further write that keeps bit 7 set does not launch a conversion.
- R10: A write to 0xA with bit 15 clear aborts any conversion in progress with no completion event. It clears the valid flag, and bits 14:5 keep the last result.
- R11: A write with bit 7 set and bit 15 clear launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; all phase timing counts these cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address for write and read |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| adc_sync_i | input | 1 | External conversion sync strobe |
| chan_data_i | input | NUM_CH*RES_W | Sampled value for each input, input n at bits n*RES_W upward |
| irq_evt_o | output | IRQ_W | Interrupt source vector; completion pulses bit IRQ_BIT |

## Verification
A phase counter that is off by even one cycle moves the completion pulse away from cycle 153 after launch, or away from 102 cycles after a late sync edge. The bench measures that latency exactly on every conversion. A wrong latched selector or a wrong sample point shows as the wrong value in bits 14:5 as soon as the result becomes valid. A bad launch or abort decode shows at the ports in two ways: a missing or extra completion event within a few hundred cycles, or a valid flag that stays set when it should have cleared.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned SEL_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'hA;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 4'hB;

  localparam int unsigned B_SYNC   = 0;
  localparam int unsigned B_SEL_LO = 2;
  localparam int unsigned B_START  = 7;
  localparam int unsigned B_EN     = 15;
  localparam int unsigned B_VALID  = 15;
  localparam int unsigned B_RES_LO = 5;

  // implemented control bits: en, start, ext ref, sel[2:0], bypass, sync
  localparam logic [REG_W-1:0] CTRL_MASK = 16'h80BF;

  typedef enum logic [1:0] {ST_IDLE, ST_SEL, ST_WAIT, ST_CONV} seq_state_e;
endpackage

// File: rtl/adc_chan_mux.sv
`timescale 1ns/1ps
module adc_chan_mux #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [NUM_CH*RES_W-1:0] chan_data_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [RES_W-1:0]        sample_o
);
  localparam int unsigned SLOTS = 2**SEL_W;

  logic [RES_W-1:0] slot_w [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_CH) begin : g_used
      assign slot_w[g] = chan_data_i[g*RES_W +: RES_W];
    end else begin : g_pad
      assign slot_w[g] = '0;
    end
  end

  assign sample_o = slot_w[sel_i];
endmodule

// File: rtl/adc_ctrl_regs.sv
`timescale 1ns/1ps
module adc_ctrl_regs
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [RES_W-1:0]  result_i,
  input  logic              valid_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              sync_en_o,
  output logic              launch_o,
  output logic              abort_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] data_word;
  logic             wr_ctrl;

  assign wr_ctrl   = we_i && (addr_i == ADDR_CTRL);
  // launch only on a 0->1 change of the stored start bit
  assign launch_o  = wr_ctrl && wdata_i[B_EN] && wdata_i[B_START] && !ctrl_q[B_START];
  assign abort_o   = wr_ctrl && !wdata_i[B_EN];
  assign sel_o     = ctrl_q[B_SEL_LO +: SEL_W];
  assign sync_en_o = ctrl_q[B_SYNC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata_i & CTRL_MASK;
  end

  always_comb begin
    data_word                      = '0;
    data_word[B_VALID]             = valid_i;
    data_word[B_RES_LO +: RES_W]   = result_i;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_DATA: rdata_o = data_word;
      default:   rdata_o = '0;
    endcase
  end

  assert_ctrl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(ctrl_q));
  assert_start_latched_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> ctrl_q[B_START] && ctrl_q[B_EN]);
  assert_no_launch_disabled_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !launch_o);
endmodule

// File: rtl/adc_conv_seq.sv
`timescale 1ns/1ps
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W    = 10,
  parameter int unsigned SEL_CYC  = 51,
  parameter int unsigned CONV_CYC = 102
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             abort_i,
  input  logic             sync_en_i,
  input  logic             sync_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [RES_W-1:0] sample_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic             done_o
);
  localparam int unsigned MAX_CYC = (SEL_CYC > CONV_CYC) ? SEL_CYC : CONV_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SEL_LAST  = CNT_W'(SEL_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic [RES_W-1:0] samp_q;
  logic [RES_W-1:0] res_q;
  logic             valid_q;
  logic             done_q;
  logic [SEL_W-1:0] sel_q;
  logic             gate_open;

  assign gate_open = !sync_en_i || seen_q || sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      samp_q  <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      sel_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        valid_q <= 1'b0;
      end else if (launch_i) begin
        state_q <= ST_SEL;
        cnt_q   <= '0;
        valid_q <= 1'b0;
        seen_q  <= 1'b0;
        sel_q   <= sel_i;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_SEL: begin
            if (sync_i) seen_q <= 1'b1;
            if (cnt_q == SEL_LAST) begin
              cnt_q <= '0;
              if (gate_open) begin
                state_q <= ST_CONV;
                samp_q  <= sample_i;
              end else begin
                state_q <= ST_WAIT;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_WAIT: begin
            if (sync_i || !sync_en_i) begin
              state_q <= ST_CONV;
              samp_q  <= sample_i;
              cnt_q   <= '0;
            end
          end
          ST_CONV: begin
            if (cnt_q == CONV_LAST) begin
              state_q <= ST_IDLE;
              cnt_q   <= '0;
              res_q   <= samp_q;
              valid_q <= 1'b1;
              done_q  <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sel_o    = sel_q;
  assign result_o = res_q;
  assign valid_o  = valid_q;
  assign done_o   = done_q;

  assert_sel_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEL) |-> (cnt_q < CNT_W'(SEL_CYC)));
  assert_conv_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |-> (cnt_q < CNT_W'(CONV_CYC)));
  assert_launch_clears_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> !valid_o && (state_q == ST_SEL));
  assert_abort_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == ST_IDLE) && !valid_o && !done_o && $stable(res_q));
  assert_wait_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !sync_i && sync_en_i && !abort_i && !launch_i) |=> (state_q == ST_WAIT));
  assert_done_sets_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> valid_o && $past(state_q == ST_CONV));
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl #(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned RES_W    = 10,
  parameter int unsigned SEL_CYC  = 51,
  parameter int unsigned CONV_CYC = 102,
  parameter int unsigned IRQ_W    = 16,
  parameter int unsigned IRQ_BIT  = 11
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [3:0]              reg_addr_i,
  input  logic [15:0]             reg_wdata_i,
  output logic [15:0]             reg_rdata_o,
  input  logic                    adc_sync_i,
  input  logic [NUM_CH*RES_W-1:0] chan_data_i,
  output logic [IRQ_W-1:0]        irq_evt_o
);
  import adc_seq_pkg::*;

  logic [SEL_W-1:0] ctrl_sel, conv_sel;
  logic             sync_en, launch, abort;
  logic [RES_W-1:0] sample, result;
  logic             valid, done;

  adc_ctrl_regs #(.RES_W(RES_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .result_i  (result),
    .valid_i   (valid),
    .sel_o     (ctrl_sel),
    .sync_en_o (sync_en),
    .launch_o  (launch),
    .abort_o   (abort),
    .rdata_o   (reg_rdata_o)
  );

  adc_chan_mux #(.NUM_CH(NUM_CH), .RES_W(RES_W), .SEL_W(SEL_W)) u_mux (
    .chan_data_i (chan_data_i),
    .sel_i       (conv_sel),
    .sample_o    (sample)
  );

  adc_conv_seq #(.RES_W(RES_W), .SEL_CYC(SEL_CYC), .CONV_CYC(CONV_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .abort_i   (abort),
    .sync_en_i (sync_en),
    .sync_i    (adc_sync_i),
    .sel_i     (ctrl_sel),
    .sample_i  (sample),
    .sel_o     (conv_sel),
    .result_o  (result),
    .valid_o   (valid),
    .done_o    (done)
  );

  for (genvar g = 0; g < IRQ_W; g++) begin : g_irq
    if (g == IRQ_BIT) begin : g_adc
      assign irq_evt_o[g] = done;
    end else begin : g_idle
      assign irq_evt_o[g] = 1'b0;
    end
  end

  assert_irq_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_evt_o));
  assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_evt_o[IRQ_BIT] |=> !irq_evt_o[IRQ_BIT]);
endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  localparam int NCH = 8;
  localparam int RW  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0;
  logic [3:0]        addr = 4'h0;
  logic [15:0]       wdata = '0;
  logic [15:0]       rdata;
  logic              sync = 1'b0;
  logic [NCH*RW-1:0] chan = '0;
  logic [15:0]       irq;

  int errs = 0;
  int checks = 0;
  bit fin = 1'b0;
  logic [RW-1:0] last_res;

  always #2.5 clk = ~clk;

  adc_seq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .adc_sync_i(sync),
    .chan_data_i(chan), .irq_evt_o(irq)
  );

  function automatic logic [15:0] exp_data(input logic v, input logic [RW-1:0] r);
    return {v, r, 5'b00000};
  endfunction

  function automatic int exp_lat(input bit sync_mode, input int ks);
    int late;
    late = ks + 1 + 102;
    if (!sync_mode || late < 153) return 153;
    return late;
  endfunction

  function automatic logic [15:0] ctrl_word(input bit en, input bit st, input logic [2:0] sel, input bit sm);
    return {en, 7'b0, st, 2'b0, sel, 1'b0, sm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic start_conv(input logic [2:0] sel, input bit sm);
    wr(4'hA, ctrl_word(1'b1, 1'b0, sel, sm));
    wr(4'hA, ctrl_word(1'b1, 1'b1, sel, sm));
  endtask

  // counts negedges until the event; pulses sync at negedge ks; flags stray irq bits
  task automatic wait_evt(input int maxc, input int ks, output int lat, output bit stray);
    lat = -1; stray = 1'b0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if ((irq & ~16'h0800) != 16'h0) stray = 1'b1;
      if (irq[11]) begin
        lat = i;
        sync = 1'b0;
        break;
      end
      sync = (i == ks);
    end
    sync = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      errs++; checks++;
      $display("FAIL watchdog R5 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int lat;
    bit stray;
    int seed;
    seed = 7321;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'hA, v); chk("R1 ctrl reset", v, 16'h0000);
    rd(4'hB, v); chk("R1 data reset", v, 16'h0000);
    chk("R1 irq reset", irq, 16'h0000);

    // R2 readback mask, R11 start without enable
    wr(4'hA, 16'h7FFF);
    rd(4'hA, v); chk("R2 ctrl mask", v, 16'h00BF);
    wr(4'h3, 16'hFFFF);
    rd(4'hA, v); chk("R2 other addr write ignored", v, 16'h00BF);
    rd(4'h3, v); chk("R2 unmapped read", v, 16'h0000);
    wait_evt(250, 0, lat, stray);
    chk("R11 no launch when disabled", lat, -1);
    rd(4'hB, v); chk("R11 valid stays clear", v, 16'h0000);
    wr(4'hA, 16'h0000);

    // directed: channel 5, no sync, exact latency
    for (int c = 0; c < NCH; c++) chan[c*RW +: RW] = RW'(c * 97 + 13);
    start_conv(3'd5, 1'b0);
    rd(4'hB, v); chk("R4 valid cleared at launch", v[15], 1'b0);
    wait_evt(400, 0, lat, stray);
    chk("R5 latency no sync", lat, 153);
    chk("R8 stray irq bits", stray, 1'b0);
    @(negedge clk);
    chk("R8 event one cycle", irq[11], 1'b0);
    rd(4'hB, v); chk("R3 R6 data word ch5", v, exp_data(1'b1, RW'(5 * 97 + 13)));
    last_res = RW'(5 * 97 + 13);

    // R9: start still high, rewrite does not relaunch
    wr(4'hA, ctrl_word(1'b1, 1'b1, 3'd5, 1'b0));
    wait_evt(250, 0, lat, stray);
    chk("R9 no retrigger", lat, -1);
    rd(4'hB, v); chk("R9 valid kept", v, exp_data(1'b1, last_res));

    // constrained random conversions
    for (int n = 0; n < 24; n++) begin
      logic [2:0] sel;
      bit sm;
      int ks, e;
      for (int c = 0; c < NCH; c++) chan[c*RW +: RW] = RW'($urandom);
      sel = 3'($urandom);
      sm  = 1'($urandom);
      ks  = 1 + ($urandom % 130);
      if (n == 0) begin sm = 1'b1; ks = 50; end
      if (n == 1) begin sm = 1'b1; ks = 51; end
      if (n == 2) begin sm = 1'b1; ks = 120; end
      e = exp_lat(sm, ks);
      start_conv(sel, sm);
      wait_evt(400, ks, lat, stray);
      if (sm) chk($sformatf("R7 sync latency ks=%0d", ks), lat, e);
      else    chk("R5 R7 latency sync ignored", lat, e);
      chk("R8 stray irq bits", stray, 1'b0);
      rd(4'hB, v);
      chk($sformatf("R6 R3 result ch%0d", sel), v, exp_data(1'b1, chan[sel*RW +: RW]));
      last_res = chan[sel*RW +: RW];
    end

    // R4 restart during conversion
    start_conv(3'd2, 1'b0);
    repeat (39) @(negedge clk);
    wr(4'hA, ctrl_word(1'b1, 1'b0, 3'd2, 1'b0));
    wr(4'hA, ctrl_word(1'b1, 1'b1, 3'd2, 1'b0));
    wait_evt(400, 0, lat, stray);
    chk("R4 restart latency", lat, 153);
    rd(4'hB, v); chk("R4 restart result", v, exp_data(1'b1, chan[2*RW +: RW]));
    last_res = chan[2*RW +: RW];

    // R10 abort mid conversion
    chan[6*RW +: RW] = ~last_res;
    start_conv(3'd6, 1'b0);
    repeat (60) @(negedge clk);
    wr(4'hA, ctrl_word(1'b0, 1'b0, 3'd6, 1'b0));
    wait_evt(250, 0, lat, stray);
    chk("R10 abort no event", lat, -1);
    rd(4'hB, v); chk("R10 result kept valid clear", v, exp_data(1'b0, last_res));
    rd(4'hA, v); chk("R10 ctrl after abort", v, 16'h0018);

    // R10 disable write after completion clears valid
    start_conv(3'd6, 1'b0);
    wait_evt(400, 0, lat, stray);
    chk("R5 latency after abort", lat, 153);
    wr(4'hA, 16'h0000);
    rd(4'hB, v); chk("R10 disable clears valid", v, exp_data(1'b0, ~last_res));

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule